// File: doc/BRIEF.md
# Single-Clock FIFO with Narrow Pointers and Band-Tracking Flags

This block is a synchronous queue with 2^AW entries, used inside one clock domain between a producer and a consumer. Its write and read pointers are only AW bits wide. Their modular difference has 2^AW possible values, but the queue can hold anywhere from zero to 2^AW words, which is 2^AW+1 distinct fill levels. When the two pointers are equal, the difference alone cannot say whether the queue is empty or full.

To settle this, the block keeps two registered flags, near-empty and near-full. They are decoded from the two most significant bits of the next pointer difference. A difference whose top two bits are 01 sets near-empty and clears near-full. A difference whose top two bits are 10 does the opposite. The other two bands leave both flags as they are. The difference moves by at most one per cycle, so it cannot get from one end band to the other without passing through both middle bands. When the pointers are equal, the surviving flag therefore tells empty from full.

The head word is always presented on the read data port while the queue is not empty. A read consumes that word on the clock edge.

Top module: `nbp_fifo`

## Requirements
- R1: After reset, both pointers are zero. The outputs read empty=1, full=0 and depth=0.
- R2: A write accepted while not full stores wr_data. While not empty, rd_data shows the oldest stored word, and words leave in the order they were written.
- R3: The depth output equals the number of words held, from 0 to 2^AW. It changes by +1 for each accepted write and by −1 for each accepted read, and it shows the new value one clock after the edge that accepted them.
- R4: After 2^AW writes with no reads, full=1 and depth=2^AW. A write requested while full is ignored: depth and the stored contents stay unchanged.
- R5: A read requested while empty is ignored: depth stays 0 and empty stays 1.
- R6: When the queue is neither full nor empty, a write and a read requested in the same cycle are both accepted. Depth stays the same and both pointers advance.
- R7: Exactly one of the two band flags is set at any time. With equal pointers, the queue reports empty if the difference last passed through top bits 01, and full if it last passed through top bits 10. This holds at every pointer offset.
- R8: empty and full are never both 1. empty=1 exactly when depth=0, and full=1 exactly when depth=2^AW.
- R9: When full, a simultaneous write and read accepts only the read, so depth becomes 2^AW−1. When empty, a simultaneous write and read accepts only the write, so depth becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Request to store wr_data |
| wr_data | input | DW | Word to store |
| full | output | 1 | Queue holds 2^AW words |
| rd_en | input | 1 | Request to consume the head word |
| rd_data | output | DW | Head word, valid while not empty |
| empty | output | 1 | Queue holds no words |
| depth | output | AW+1 | Number of words held |

## Verification
Some properties are checked by the assertions on every cycle:
- empty and full are never both set, and exactly one band flag is set;
- a full queue never accepts a write, and an empty queue never accepts a read;
- depth steps by exactly the accepted writes minus the accepted reads.

Other behaviour is visible only in the bench's scenarios:
- data order, and the fact that a write dropped while full leaves the contents intact;
- correct empty/full resolution after the pointers have wrapped to many different offsets, which needs long write-heavy and read-heavy runs.

// File: rtl/nbp_fifo_pkg.sv
package nbp_fifo_pkg;

  // Classification of the two top bits of the pointer difference.
  typedef enum logic [1:0] {
    BAND_LOW  = 2'b00,
    BAND_RISE = 2'b01,
    BAND_FALL = 2'b10,
    BAND_TOP  = 2'b11
  } band_e;

  function automatic band_e band_of(input logic [1:0] top_bits);
    band_e b;
    unique case (top_bits)
      2'b01:   b = BAND_RISE;
      2'b10:   b = BAND_FALL;
      2'b11:   b = BAND_TOP;
      default: b = BAND_LOW;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/nbp_ptr.sv
module nbp_ptr #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_next
);

  assign ptr_next = adv ? ptr + AW'(1) : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_next;
  end

endmodule

// File: rtl/nbp_band_track.sv
module nbp_band_track
  import nbp_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] gap_top_next,
  output logic       near_empty,
  output logic       near_full
);

  band_e band_next;
  assign band_next = band_of(gap_top_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      near_empty <= 1'b1;
      near_full  <= 1'b0;
    end else begin
      case (band_next)
        BAND_RISE: begin
          near_empty <= 1'b1;
          near_full  <= 1'b0;
        end
        BAND_FALL: begin
          near_empty <= 1'b0;
          near_full  <= 1'b1;
        end
        default: begin
          near_empty <= near_empty;
          near_full  <= near_full;
        end
      endcase
    end
  end

endmodule

// File: rtl/nbp_store.sv
module nbp_store #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int SLOTS = 1 << AW;

  logic [DW-1:0] cells [SLOTS];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/nbp_fifo.sv
module nbp_fifo #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic [AW:0]   depth
);

  localparam int          NPTR     = 2;
  localparam int          WR_IDX   = 0;
  localparam int          RD_IDX   = 1;
  localparam logic [AW:0] DEPTH_MX = {1'b1, {AW{1'b0}}};

  // Modular difference of two narrow pointers.
  function automatic logic [AW-1:0] ptr_gap(input logic [AW-1:0] wp,
                                            input logic [AW-1:0] rp);
    return wp - rp;
  endfunction

  logic          wr_fire, rd_fire;
  logic [1:0]    step;
  logic [AW-1:0] cur [NPTR];
  logic [AW-1:0] nxt [NPTR];
  logic [AW-1:0] gap, gap_next;
  logic          gap_zero;
  logic          near_empty, near_full;

  assign wr_fire      = wr_en & ~full;
  assign rd_fire      = rd_en & ~empty;
  assign step[WR_IDX] = wr_fire;
  assign step[RD_IDX] = rd_fire;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    nbp_ptr #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (step[g]),
      .ptr      (cur[g]),
      .ptr_next (nxt[g])
    );
  end

  assign gap      = ptr_gap(cur[WR_IDX], cur[RD_IDX]);
  assign gap_next = ptr_gap(nxt[WR_IDX], nxt[RD_IDX]);
  assign gap_zero = (gap == '0);

  nbp_band_track u_band (
    .clk          (clk),
    .rst_n        (rst_n),
    .gap_top_next (gap_next[AW-1:AW-2]),
    .near_empty   (near_empty),
    .near_full    (near_full)
  );

  assign empty = gap_zero & near_empty;
  assign full  = gap_zero & near_full;
  assign depth = empty ? '0 : (full ? DEPTH_MX : {1'b0, gap});

  nbp_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (cur[WR_IDX]),
    .wdata (wr_data),
    .raddr (cur[RD_IDX]),
    .rdata (rd_data)
  );

endmodule

// File: rtl/nbp_fifo_chk.sv
module nbp_fifo_chk #(
  parameter int AW = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_fire,
  input logic        rd_fire,
  input logic        full,
  input logic        empty,
  input logic        near_empty,
  input logic        near_full,
  input logic [AW:0] depth
);

  logic [AW:0] inc_w, dec_r;
  assign inc_w = {{AW{1'b0}}, wr_fire};
  assign dec_r = {{AW{1'b0}}, rd_fire};

  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R4
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_fire);

  // R5
  no_read_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_fire);

  // R7
  one_band_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({near_empty, near_full}) == 1);

  // R3
  depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> depth == $past(depth) + $past(inc_w) - $past(dec_r));

  // R6
  both_fire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> $stable(depth));

endmodule

bind nbp_fifo nbp_fifo_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_fire    (wr_fire),
  .rd_fire    (rd_fire),
  .full       (full),
  .empty      (empty),
  .near_empty (near_empty),
  .near_full  (near_full),
  .depth      (depth)
);

// File: tb/tb_nbp_fifo.sv
`timescale 1ns/1ps
module tb_nbp_fifo;

  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int CAP = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          full, empty;
  logic [AW:0]   depth;

  int total = 0;
  int bad = 0;
  int model_q[$];
  int full_hits = 0;
  int empty_hits = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nbp_fifo #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .depth(depth)
  );

  function automatic int exp_depth();
    return model_q.size();
  endfunction

  function automatic bit exp_full();
    return model_q.size() == CAP;
  endfunction

  function automatic bit exp_empty();
    return model_q.size() == 0;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Sample at the falling edge, after the previous rising edge settled.
  task automatic check_all(input string req);
    chk(req, "depth", int'(depth), exp_depth());
    chk(req, "empty", int'(empty), int'(exp_empty()));
    chk(req, "full",  int'(full),  int'(exp_full()));
    if (!exp_empty()) chk(req, "rd_data", int'(rd_data), model_q[0]);
  endtask

  // Drive at the falling edge, apply the model after the rising edge, return at the next falling edge.
  task automatic step(input bit w, input bit r, input int d);
    bit wacc, racc;
    wr_en   = w;
    rd_en   = r;
    wr_data = DW'(d);
    wacc = w && (model_q.size() < CAP);
    racc = r && (model_q.size() > 0);
    @(posedge clk);
    #1;
    if (racc) void'(model_q.pop_front());
    if (wacc) model_q.push_back(d & ((1 << DW) - 1));
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (exp_full())  full_hits++;
    if (exp_empty()) empty_hits++;
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: state right after reset
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R5: reads on an empty queue are dropped
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0);
      check_all("R5");
    end

    // R2: stored order and head presentation
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 8'h30 + i);
      check_all("R2");
    end
    for (int i = 0; i < 2; i++) begin
      step(0, 1, 0);
      check_all("R2");
    end

    // R4: fill up, then try extra writes
    while (model_q.size() < CAP) begin
      step(1, 0, $urandom_range(255));
      check_all("R3");
    end
    chk("R4", "full after fill", int'(full), 1);
    chk("R4", "depth at cap", int'(depth), CAP);
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 8'hEE);
      check_all("R4");
    end
    // R4: drain to show the dropped writes left contents intact
    while (model_q.size() > 0) begin
      step(0, 1, 0);
      check_all("R4");
    end
    // R7: equal pointers at a new offset resolve as empty
    chk("R7", "empty after drain", int'(empty), 1);

    // R9: simultaneous request on a full queue
    while (model_q.size() < CAP) step(1, 0, $urandom_range(255));
    step(1, 1, 8'h5A);
    chk("R9", "depth after rw on full", int'(depth), CAP - 1);
    check_all("R9");
    while (model_q.size() > 0) step(0, 1, 0);
    // R9: simultaneous request on an empty queue
    step(1, 1, 8'hA5);
    chk("R9", "depth after rw on empty", int'(depth), 1);
    check_all("R9");

    // R6: balanced traffic at a partial fill
    while (model_q.size() < CAP / 2) step(1, 0, $urandom_range(255));
    for (int i = 0; i < 20; i++) begin
      step(1, 1, $urandom_range(255));
      check_all("R6");
      chk("R6", "depth steady", int'(depth), CAP / 2);
    end

    // R7 R8: random phases, alternately write-heavy and read-heavy
    for (int ph = 0; ph < 40; ph++) begin
      for (int i = 0; i < 60; i++) begin
        bit w, r;
        int p;
        p = $urandom_range(99);
        w = (ph % 2 == 0) ? (p < 75) : (p < 25);
        r = ($urandom_range(99) < 50);
        step(w, r, $urandom_range(255));
        check_all("R8");
        if (model_q.size() == 0 || model_q.size() == CAP)
          check_all("R7");
      end
    end
    chk("R7", "full reached in random run", int'(full_hits > 3), 1);
    chk("R7", "empty reached in random run", int'(empty_hits > 3), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule